// File: doc/BRIEF.md
# Dual-Mode Serial Management Slave

This block is the slave end of a two-wire serial management link. It runs on the management clock, samples the data line on rising edges and drives it on falling edges. Each frame starts with a run of ones, a start pattern, a read or write opcode, a 5-bit device field and a 5-bit register field, then a turnaround and 16 data bits. Bit 2 of the device field picks one of two targets. When it is clear, the frame reaches a small bank of 16-bit standard registers, and only if the low two device bits equal the strapped port address. When it is set, the frame reaches a 128-entry bank of 8-bit configuration registers. The register number is then the top two device bits placed above the 5-bit register field.

On the register side the block has a single-cycle read strobe and a single-cycle write strobe. Both share a space select, a 7-bit address and a 16-bit write word. Read data must be valid during the read strobe cycle. The data line is split into input, output and output enable, so the pad cell can be placed outside the block.

The controller has seven states. `ST_PRE` counts consecutive ones. A zero after at least 32 ones moves it to `ST_SOF`. `ST_SOF` needs a one to move on to `ST_OP`; otherwise it returns to `ST_PRE`. `ST_OP` reads two bits and moves to `ST_PHY` on a read or write code. Any other code sends it back to `ST_PRE`. `ST_PHY` takes five bits and then moves to `ST_REG`. `ST_REG` takes five bits, routes the access and then moves to `ST_TA`. `ST_TA` takes two bits and then moves to `ST_DATA`. `ST_DATA` takes sixteen bits and then returns to `ST_PRE` with the ones count cleared.

Top module: `mdio_dual_slave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive ones followed by the start pattern 0 then 1. With 31 ones, or with a start pattern of 0 then 0, no output enable and no register strobe follow.
- R2: Opcode 1,0 is a read and opcode 0,1 is a write. Any other code drops the frame. The next frame is accepted only after a new run of 32 ones.
- R3: When device bit 2 is 0, the slave answers only if device bits 1:0 equal `port_addr`. Device bits 4:3 have no effect. A mismatched read leaves the output enable low, and a mismatched write gives no write strobe.
- R4: In standard mode, register numbers above 5 give a read of all zeros with normal line timing, and a write produces no write strobe. Strobes in standard mode only ever carry addresses 0 to 5 with `reg_space`=0.
- R5: When device bit 2 is 1, `reg_space`=1 and `reg_addr` = {device[4:3], register[4:0]}. Device bits 1:0 and `port_addr` have no effect.
- R6: A configuration read returns 0x00 in data bits 15:8 and `reg_rdata[7:0]` in bits 7:0.
- R7: A configuration write presents `reg_wdata` with bits 15:8 zero and bits 7:0 taken from the low frame byte.
- R8: On an answered read, `mdio_oe` is high from the second turnaround bit through the last data bit (17 bit times). The slave drives 0 for that turnaround bit and then the data MSB first. At all other times `mdio_oe` is low.
- R9: `reg_rd_en` pulses for one cycle right after the register field and before the second turnaround bit. `reg_wr_en` pulses for one cycle after the 16th data bit. The two never coincide.
- R10: While reset is held, `mdio_oe`, `reg_rd_en` and `reg_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 2 | Strapped address matched in standard mode |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven by the slave |
| mdio_oe | output | 1 | Pad output enable |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_space | output | 1 | 0 for standard bank, 1 for configuration bank |
| reg_addr | output | 7 | Register number |
| reg_wdata | output | 16 | Write word |
| reg_rdata | input | 16 | Read word, valid during `reg_rd_en` |

## Verification
A state or bit counter that is off by one shifts every later field. This shows at the ports within that frame. The output enable opens one bit early or late, read data comes back shifted or without its leading zero, or a strobe carries the wrong address. A stuck ones counter or a wrong exit from the opcode state shows on the next frame. That frame is then either ignored when it should be answered, or answered after a bad start or too short a preamble. The table of frames and the directed malformed frames are placed to expose these cases.

// File: rtl/mdio_dual_pkg.sv
package mdio_dual_pkg;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_SOF,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DATA
    } mdio_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_route.sv
module mdio_route #(
    parameter int FIELD_W  = 5,
    parameter int ADDR_W   = 7,
    parameter int SEL_BIT  = 2,
    parameter int STD_LAST = 5,
    parameter int PORT_W   = 2
) (
    input  logic [FIELD_W-1:0] phyad,
    input  logic [FIELD_W-1:0] regad,
    input  logic [PORT_W-1:0]  port_addr,
    output logic               cfg_sel,
    output logic               hit,
    output logic               reg_ok,
    output logic [ADDR_W-1:0]  addr
);
    localparam int HI_W = ADDR_W - FIELD_W;

    always_comb begin
        cfg_sel = phyad[SEL_BIT];
        if (cfg_sel) begin
            addr   = {phyad[FIELD_W-1 -: HI_W], regad};
            hit    = 1'b1;
            reg_ok = 1'b1;
        end else begin
            addr   = ADDR_W'(regad);
            hit    = (phyad[PORT_W-1:0] == port_addr);
            reg_ok = (regad <= FIELD_W'(STD_LAST));
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_dual_pkg::*;
#(
    parameter int PRE_LEN  = 32,
    parameter int DATA_W   = 16,
    parameter int CFG_W    = 8,
    parameter int FIELD_W  = 5,
    parameter int ADDR_W   = 7,
    parameter int SEL_BIT  = 2,
    parameter int STD_LAST = 5,
    parameter int PORT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [PORT_W-1:0] port_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic              space_q,
    output logic              valid_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              tx_load,
    output logic              tx_shift,
    output logic              tx_drive_ta,
    output logic              tx_drive_data
);
    localparam int PRE_CW = $clog2(PRE_LEN + 1);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  FLD_LAST  = CNT_W'(FIELD_W - 1);
    localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [PRE_CW-1:0] PRE_FULL  = PRE_CW'(PRE_LEN);

    mdio_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [PRE_CW-1:0]  pre_q, pre_d;

    logic               op_hi_q;
    logic               is_read_q;
    logic               hit_q;
    logic [FIELD_W-1:0] phy_sr;
    logic [FIELD_W-1:0] reg_sr;
    logic [FIELD_W-1:0] reg_next;
    logic [DATA_W-1:0]  wd_sr;
    logic [DATA_W-1:0]  wd_next;
    logic [1:0]         opcode;

    logic               rt_cfg;
    logic               rt_hit;
    logic               rt_ok;
    logic [ADDR_W-1:0]  rt_addr;

    assign reg_next = {reg_sr[FIELD_W-2:0], mdio_i};
    assign wd_next  = {wd_sr[DATA_W-2:0], mdio_i};
    assign opcode   = {op_hi_q, mdio_i};

    mdio_route #(
        .FIELD_W (FIELD_W),
        .ADDR_W  (ADDR_W),
        .SEL_BIT (SEL_BIT),
        .STD_LAST(STD_LAST),
        .PORT_W  (PORT_W)
    ) u_route (
        .phyad    (phy_sr),
        .regad    (reg_next),
        .port_addr(port_addr),
        .cfg_sel  (rt_cfg),
        .hit      (rt_hit),
        .reg_ok   (rt_ok),
        .addr     (rt_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        pre_d   = '0;
        unique case (state_q)
            ST_PRE: begin
                cnt_d = '0;
                if (mdio_i) begin
                    pre_d = (pre_q == PRE_FULL) ? pre_q : pre_q + 1'b1;
                end else if (pre_q == PRE_FULL) begin
                    state_d = ST_SOF;
                end
            end
            ST_SOF: begin
                cnt_d   = '0;
                state_d = mdio_i ? ST_OP : ST_PRE;
            end
            ST_OP: begin
                if (cnt_q == CNT_W'(1)) begin
                    cnt_d = '0;
                    if (opcode == OPC_READ || opcode == OPC_WRITE) begin
                        state_d = ST_PHY;
                    end else begin
                        state_d = ST_PRE;
                    end
                end
            end
            ST_PHY: begin
                if (cnt_q == FLD_LAST) begin
                    cnt_d   = '0;
                    state_d = ST_REG;
                end
            end
            ST_REG: begin
                if (cnt_q == FLD_LAST) begin
                    cnt_d   = '0;
                    state_d = ST_TA;
                end
            end
            ST_TA: begin
                if (cnt_q == CNT_W'(1)) begin
                    cnt_d   = '0;
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (cnt_q == DATA_LAST) begin
                    cnt_d   = '0;
                    state_d = ST_PRE;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_PRE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRE;
            cnt_q   <= '0;
            pre_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pre_q   <= pre_d;
        end
    end

    // field capture and register port outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_hi_q   <= 1'b0;
            is_read_q <= 1'b0;
            hit_q     <= 1'b0;
            valid_q   <= 1'b0;
            space_q   <= 1'b0;
            addr_q    <= '0;
            phy_sr    <= '0;
            reg_sr    <= '0;
            wd_sr     <= '0;
            wdata_q   <= '0;
            rd_en     <= 1'b0;
            wr_en     <= 1'b0;
        end else begin
            rd_en <= 1'b0;
            wr_en <= 1'b0;
            unique case (state_q)
                ST_OP: begin
                    if (cnt_q == '0) begin
                        op_hi_q <= mdio_i;
                    end else begin
                        is_read_q <= (opcode == OPC_READ);
                    end
                end
                ST_PHY: begin
                    phy_sr <= {phy_sr[FIELD_W-2:0], mdio_i};
                end
                ST_REG: begin
                    reg_sr <= reg_next;
                    if (cnt_q == FLD_LAST) begin
                        space_q <= rt_cfg;
                        addr_q  <= rt_addr;
                        hit_q   <= rt_hit;
                        valid_q <= rt_ok;
                        rd_en   <= is_read_q && rt_hit && rt_ok;
                    end
                end
                ST_DATA: begin
                    if (!is_read_q) begin
                        wd_sr <= wd_next;
                        if (cnt_q == DATA_LAST) begin
                            wr_en   <= hit_q && valid_q;
                            wdata_q <= space_q
                                     ? {{(DATA_W-CFG_W){1'b0}}, wd_next[CFG_W-1:0]}
                                     : wd_next;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign tx_load       = (state_q == ST_TA) && (cnt_q == '0);
    assign tx_shift      = (state_q == ST_DATA);
    assign tx_drive_ta   = is_read_q && hit_q && (state_q == ST_TA) && (cnt_q == CNT_W'(1));
    assign tx_drive_data = is_read_q && hit_q && (state_q == ST_DATA);

endmodule

// File: rtl/mdio_tx.sv
module mdio_tx #(
    parameter int DATA_W = 16,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              drive_ta,
    input  logic              drive_data,
    input  logic              space,
    input  logic              valid,
    input  logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] fmt;

    always_comb begin
        if (!valid) begin
            fmt = '0;
        end else if (space) begin
            fmt = {{(DATA_W-CFG_W){1'b0}}, rdata[CFG_W-1:0]};
        end else begin
            fmt = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= fmt;
        end else if (shift) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    // launch on the falling edge, half a bit ahead of the master's sample
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
        end else begin
            mdio_oe <= drive_ta || drive_data;
            mdio_o  <= drive_data ? sh_q[DATA_W-1] : 1'b0;
        end
    end

endmodule

// File: rtl/mdio_dual_slave.sv
module mdio_dual_slave #(
    parameter int PRE_LEN  = 32,
    parameter int DATA_W   = 16,
    parameter int CFG_W    = 8,
    parameter int FIELD_W  = 5,
    parameter int ADDR_W   = 7,
    parameter int SEL_BIT  = 2,
    parameter int STD_LAST = 5,
    parameter int PORT_W   = 2
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_addr,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic              reg_space,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic valid;
    logic tx_load;
    logic tx_shift;
    logic tx_drive_ta;
    logic tx_drive_data;

    mdio_frame_fsm #(
        .PRE_LEN (PRE_LEN),
        .DATA_W  (DATA_W),
        .CFG_W   (CFG_W),
        .FIELD_W (FIELD_W),
        .ADDR_W  (ADDR_W),
        .SEL_BIT (SEL_BIT),
        .STD_LAST(STD_LAST),
        .PORT_W  (PORT_W)
    ) u_fsm (
        .clk          (mdc),
        .rst_n        (rst_n),
        .mdio_i       (mdio_i),
        .port_addr    (port_addr),
        .rd_en        (reg_rd_en),
        .wr_en        (reg_wr_en),
        .space_q      (reg_space),
        .valid_q      (valid),
        .addr_q       (reg_addr),
        .wdata_q      (reg_wdata),
        .tx_load      (tx_load),
        .tx_shift     (tx_shift),
        .tx_drive_ta  (tx_drive_ta),
        .tx_drive_data(tx_drive_data)
    );

    mdio_tx #(
        .DATA_W(DATA_W),
        .CFG_W (CFG_W)
    ) u_tx (
        .clk       (mdc),
        .rst_n     (rst_n),
        .load      (tx_load),
        .shift     (tx_shift),
        .drive_ta  (tx_drive_ta),
        .drive_data(tx_drive_data),
        .space     (reg_space),
        .valid     (valid),
        .rdata     (reg_rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

endmodule

// File: rtl/mdio_dual_slave_chk.sv
module mdio_dual_slave_chk #(
    parameter int DATA_W   = 16,
    parameter int CFG_W    = 8,
    parameter int ADDR_W   = 7,
    parameter int STD_LAST = 5
) (
    input logic              mdc,
    input logic              rst_n,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              reg_rd_en,
    input logic              reg_wr_en,
    input logic              reg_space,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata
);
    localparam int RUN_W = $clog2(DATA_W + 3);

    logic [RUN_W-1:0] oe_run;

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            oe_run <= '0;
        end else if (mdio_oe) begin
            oe_run <= oe_run + 1'b1;
        end else begin
            oe_run <= '0;
        end
    end

    a_r9_rd_single: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    a_r9_wr_single: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    a_r9_no_overlap: assert property (@(posedge mdc) disable iff (!rst_n)
        !(reg_rd_en && reg_wr_en));

    a_r8_oe_follows_read: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_rd_en |=> mdio_oe);

    a_r8_ta_low: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    a_r8_oe_length: assert property (@(posedge mdc) disable iff (!rst_n)
        oe_run <= RUN_W'(DATA_W + 1));

    a_r7_cfg_upper_zero: assert property (@(posedge mdc) disable iff (!rst_n)
        (reg_wr_en && reg_space) |-> (reg_wdata[DATA_W-1:CFG_W] == '0));

    a_r4_std_range: assert property (@(posedge mdc) disable iff (!rst_n)
        ((reg_wr_en || reg_rd_en) && !reg_space) |-> (reg_addr <= ADDR_W'(STD_LAST)));

    a_r10_reset_quiet: assert property (@(posedge mdc)
        !rst_n |-> (!mdio_oe && !reg_rd_en && !reg_wr_en));

endmodule

bind mdio_dual_slave mdio_dual_slave_chk #(
    .DATA_W  (DATA_W),
    .CFG_W   (CFG_W),
    .ADDR_W  (ADDR_W),
    .STD_LAST(STD_LAST)
) u_chk (
    .mdc      (mdc),
    .rst_n    (rst_n),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .reg_rd_en(reg_rd_en),
    .reg_wr_en(reg_wr_en),
    .reg_space(reg_space),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/mdio_dual_slave_test.sv
`timescale 1ns/1ps
module mdio_dual_slave_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  port_addr = 2'b01;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;
    logic        rd_en;
    logic        wr_en;
    logic        space;
    logic [6:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    logic [15:0] last_wdata = '0;
    logic [6:0]  last_waddr = '0;
    logic        done = 1'b0;

    logic [15:0] std_mem [0:7];
    logic [7:0]  cfg_mem [0:127];

    always #2.5 clk = ~clk;

    mdio_dual_slave uut (
        .mdc      (clk),
        .rst_n    (rst_n),
        .port_addr(port_addr),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .reg_rd_en(rd_en),
        .reg_wr_en(wr_en),
        .reg_space(space),
        .reg_addr (addr),
        .reg_wdata(wdata),
        .reg_rdata(rdata)
    );

    // register model behind the port; upper byte garbage in config space
    assign rdata = !rd_en ? 16'h0000
                 : (space ? {8'hA5, cfg_mem[addr]} : std_mem[addr[2:0]]);

    always @(posedge clk) begin
        if (wr_en) begin
            if (space) cfg_mem[addr] <= wdata[7:0];
            else       std_mem[addr[2:0]] <= wdata;
            wr_count   <= wr_count + 1;
            last_wdata <= wdata;
            last_waddr <= addr;
        end
    end

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] data;
        logic        resp;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 5'b00001, 5'd3,  16'hBEEF, 1'b0, 16'h0000}, // R3 std write
        '{1'b1, 5'b11001, 5'd3,  16'h0000, 1'b1, 16'hBEEF}, // R3 bits 4:3 ignored
        '{1'b0, 5'b00010, 5'd2,  16'h1234, 1'b0, 16'h0000}, // R3 port mismatch write
        '{1'b1, 5'b00001, 5'd2,  16'h0000, 1'b1, 16'h1002}, // R3 unchanged
        '{1'b1, 5'b00010, 5'd2,  16'h0000, 1'b0, 16'h0000}, // R3 mismatch read silent
        '{1'b0, 5'b00001, 5'd7,  16'hFFFF, 1'b0, 16'h0000}, // R4 write discarded
        '{1'b1, 5'b00001, 5'd7,  16'h0000, 1'b1, 16'h0000}, // R4 read zero
        '{1'b0, 5'b10100, 5'h1F, 16'hABCD, 1'b0, 16'h0000}, // R5 cfg 0x5F
        '{1'b1, 5'b10111, 5'h1F, 16'h0000, 1'b1, 16'h00CD}, // R5 R6 readback
        '{1'b1, 5'b00101, 5'h00, 16'h0000, 1'b1, 16'h005A}, // R6 upper masked
        '{1'b1, 5'b11110, 5'h1F, 16'h0000, 1'b1, 16'h0025}, // R5 addr 0x7F
        '{1'b1, 5'b00001, 5'd5,  16'h0000, 1'b1, 16'h1005}  // R4 last std reg
    };

    function automatic string vec_req(int i);
        case (i)
            5, 6, 11: return "R4";
            7, 10:    return "R5";
            8, 9:     return "R6";
            default:  return "R3";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        mdio_i = b;
    endtask

    task automatic send_hdr(input int npre, input logic [1:0] sof, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg);
        for (int i = 0; i < npre; i++) put_bit(1'b1);
        put_bit(sof[1]); put_bit(sof[0]);
        put_bit(op[1]);  put_bit(op[0]);
        for (int i = 4; i >= 0; i--) put_bit(phy[i]);
        for (int i = 4; i >= 0; i--) put_bit(rg[i]);
    endtask

    task automatic wr_phase(input logic [15:0] d);
        put_bit(1'b1); put_bit(1'b0);
        for (int i = 15; i >= 0; i--) put_bit(d[i]);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    endtask

    task automatic rd_phase(input logic resp, input logic [15:0] exp, input string req);
        logic [15:0] got;
        bit          win_ok;
        got    = '0;
        win_ok = 1'b1;
        for (int i = 0; i < 18; i++) begin
            put_bit(1'b1);
            @(posedge clk); #1;
            if (i == 0) begin
                if (mdio_oe !== 1'b0) win_ok = 1'b0;
            end else if (i == 1) begin
                if (mdio_oe !== resp) win_ok = 1'b0;
                if (resp && mdio_o !== 1'b0) win_ok = 1'b0;
            end else begin
                if (mdio_oe !== resp) win_ok = 1'b0;
                got = {got[14:0], mdio_o};
            end
        end
        put_bit(1'b1);
        @(posedge clk); #1;
        if (mdio_oe !== 1'b0) win_ok = 1'b0;
        // R8 enable window and turnaround zero
        check(win_ok, "R8", {"enable window for ", req}, {31'd0, mdio_oe}, {31'd0, resp});
        if (resp) check(got === exp, req, "read data", {16'd0, got}, {16'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int wc;
        for (int i = 0; i < 8; i++)   std_mem[i] = 16'h1000 + 16'(i);
        for (int i = 0; i < 128; i++) cfg_mem[i] = 8'(i) ^ 8'h5A;

        repeat (3) @(posedge clk);
        #1;
        // R10 quiet during reset
        check(!mdio_oe && !rd_en && !wr_en, "R10", "reset outputs",
              {29'd0, mdio_oe, rd_en, wr_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        put_bit(1'b1);

        for (int v = 0; v < NVEC; v++) begin
            send_hdr(32, 2'b01, VEC[v].rd ? 2'b10 : 2'b01, VEC[v].phy, VEC[v].rg);
            if (VEC[v].rd) rd_phase(VEC[v].resp, VEC[v].exp, vec_req(v));
            else           wr_phase(VEC[v].data);
        end

        // R3 R4: only the matched std write and the cfg write committed
        check(wr_count == 2, "R4", "write strobe count", wr_count, 2);
        check(std_mem[2] == 16'h1002, "R3", "mismatched write left reg", std_mem[2], 16'h1002);

        // R7: cfg write word has zero upper byte
        wc = wr_count;
        send_hdr(32, 2'b01, 2'b01, 5'b00100, 5'h10);
        wr_phase(16'h7733);
        check(last_wdata == 16'h0033, "R7", "cfg write word", last_wdata, 16'h0033);
        check(last_waddr == 7'h10, "R5", "cfg write address", last_waddr, 7'h10);
        check(wr_count == wc + 1, "R9", "one write strobe", wr_count, wc + 1);

        // R1: 31 ones then a valid-looking read: ignored
        put_bit(1'b0);
        send_hdr(31, 2'b01, 2'b10, 5'b00001, 5'd3);
        rd_phase(1'b0, 16'h0, "R1");

        // R1: bad start pattern 00
        put_bit(1'b0);
        send_hdr(32, 2'b00, 2'b10, 5'b00001, 5'd3);
        rd_phase(1'b0, 16'h0, "R1");

        // R2: bad opcode 11, then a frame without new preamble: ignored
        put_bit(1'b0);
        send_hdr(32, 2'b01, 2'b11, 5'b00001, 5'd3);
        send_hdr(0, 2'b01, 2'b10, 5'b00001, 5'd3);
        rd_phase(1'b0, 16'h0, "R2");

        // R2: bad opcode 00 write attempt produces no strobe
        wc = wr_count;
        put_bit(1'b0);
        send_hdr(32, 2'b01, 2'b00, 5'b00001, 5'd1);
        wr_phase(16'h5555);
        check(wr_count == wc, "R2", "bad opcode write", wr_count, wc);

        // R1 R2: recovery with a proper preamble
        send_hdr(32, 2'b01, 2'b10, 5'b00001, 5'd3);
        rd_phase(1'b1, 16'hBEEF, "R2");

        // R5: port address has no effect in config space
        port_addr = 2'b10;
        send_hdr(32, 2'b01, 2'b10, 5'b10111, 5'h1F);
        rd_phase(1'b1, 16'h00CD, "R5");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule